// File: doc/BRIEF.md
# Shared Expander Product-Term Array

This block is the pool of shareable product terms that serves one logic group of a programmable logic fabric. It holds a set of expanders. Each expander ANDs a chosen set of literals and inverts the result, so each one is a programmable NAND gate. A literal is any signal of the group, taken true or complemented. The signals a term can use are the dedicated inputs, the interconnect lines, the macrocell feedback lines and the expander outputs. The expander outputs are presented together on one bus. Any number of macrocell product terms or control terms (clock, clear, preset, output enable) can use any expander output, and several terms in the same macrocell can use the same one.

Each expander has two fuse bits per column. One selects the true literal of that column and the other selects the complement. A configuration port writes both masks of one expander in one cycle. The expander outputs return to the array through a register. Because of this, two expanders that select each other's feedback columns form a set-reset latch that needs no macrocell. The loop settles in one clock cycle per pass and is never a combinational loop.

The parameter `SINGLE_GROUP` selects the variant used when the fabric has only one group. That variant has 64 expanders, and its interconnect columns are tied low. An active-low reset clears all fuses asynchronously. The release of reset is synchronised internally and takes effect on the second rising edge after `rst_n` goes high.

Top module: `shared_expander_array`

## Requirements
- R1: While `rst_n` is low, and afterwards until a write occurs, every fuse is clear and `exp_o` is all zeros.
- R2: When `cfg_we` is high at a rising edge after the internal reset release, both masks of expander `cfg_idx` are replaced by `cfg_true` and `cfg_comp`. No other expander changes. The new masks drive `exp_o` from that edge on.
- R3: `exp_o[k]` is the inverse of the AND of the selected literals of expander k. Bit j of the true mask selects column j, and bit j of the complement mask selects the inverse of column j.
- R4: The columns are numbered as follows. Columns 0 to 7 are `ded_i[7:0]`. Columns 8 to 31 are `icl_i[23:0]`. Columns 32 to 47 are `mcf_i[15:0]`. Columns 48 to 79 are the feedback, where column 48+j carries expander j.
- R5: A feedback column holds the value that expander output had at the previous rising edge. A term that uses it therefore follows its source one cycle later.
- R6: An expander that selects both the true and the complement literal of the same column outputs a constant 1. An expander with no literal selected outputs a constant 0.
- R7: Set up expander 10 as NAND(`ded_i[1]`, feedback of 11) and expander 11 as NAND(`ded_i[2]`, feedback of 10). This pair behaves as a set-reset latch. With `ded_i[1]` low and `ded_i[2]` high, the pair ends at `exp_o[10]`=1 and `exp_o[11]`=0. With the opposite inputs it ends at 0 and 1. With both inputs high it keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Fuse write strobe |
| cfg_idx | input | 5 | Index of the expander to write |
| cfg_true | input | 80 | True-literal mask for the written expander |
| cfg_comp | input | 80 | Complement-literal mask for the written expander |
| ded_i | input | 8 | Dedicated input columns |
| icl_i | input | 24 | Interconnect columns |
| mcf_i | input | 16 | Macrocell feedback columns |
| exp_o | output | 32 | Expander outputs, one inverted product term each |

## Verification
The assertions assume that `cfg_we` stays low while the internal reset is being released. They also assume that all inputs hold known values at every rising edge and that reset is not asserted again in the middle of a run. The bench changes every input only at the falling edge and waits three cycles after releasing `rst_n` before the first fuse write. It keeps the random masks sparse so that most terms do not collapse to a constant. A separate reference model predicts the whole output bus every cycle, including the registered feedback.

// File: rtl/sxa_pkg.sv
package sxa_pkg;
  // Default column-group sizes for one logic group.
  localparam int DEF_DED        = 8;
  localparam int DEF_ICL        = 24;
  localparam int DEF_MCF        = 16;
  localparam int EXP_MULTI      = 32;
  localparam int EXP_SINGLE     = 64;

  // Column source regions, in their fixed order inside the literal vector.
  typedef enum logic [1:0] {
    SRC_DED = 2'd0,
    SRC_ICL = 2'd1,
    SRC_MCF = 2'd2,
    SRC_FB  = 2'd3
  } col_src_e;
endpackage

// File: rtl/sxa_rst_sync.sv
module sxa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rst_s_n <= out_d;
    end
  end
endmodule

// File: rtl/sxa_fuse_bank.sv
module sxa_fuse_bank #(
  parameter  int N_EXP = 32,
  parameter  int N_IN  = 80,
  localparam int IDX_W = $clog2(N_EXP)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [N_IN-1:0]             t_in,
  input  logic [N_IN-1:0]             c_in,
  output logic [N_EXP-1:0][N_IN-1:0]  t_q,
  output logic [N_EXP-1:0][N_IN-1:0]  c_q
);
  for (genvar k = 0; k < N_EXP; k++) begin : g_row
    logic            row_en;
    logic [N_IN-1:0] t_nxt;
    logic [N_IN-1:0] c_nxt;

    always_comb begin
      row_en = we && (idx == IDX_W'(k));
      t_nxt  = row_en ? t_in : t_q[k];
      c_nxt  = row_en ? c_in : c_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q[k] <= '0;
        c_q[k] <= '0;
      end else begin
        t_q[k] <= t_nxt;
        c_q[k] <= c_nxt;
      end
    end
  end
endmodule

// File: rtl/sxa_term.sv
module sxa_term #(
  parameter int N_IN = 80
) (
  input  logic [N_IN-1:0] t_sel,
  input  logic [N_IN-1:0] c_sel,
  input  logic [N_IN-1:0] lit_x,
  output logic            term_n
);
  logic [N_IN-1:0] pass;

  always_comb begin
    // A column passes unless a selected literal of it is false.
    pass   = (lit_x | ~t_sel) & (~lit_x | ~c_sel);
    term_n = ~(&pass);
  end
endmodule

// File: rtl/sxa_fb_reg.sv
module sxa_fb_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/shared_expander_array.sv
module shared_expander_array
  import sxa_pkg::*;
#(
  parameter  int SINGLE_GROUP = 0,
  parameter  int N_DED        = DEF_DED,
  parameter  int N_ICL        = DEF_ICL,
  parameter  int N_MCF        = DEF_MCF,
  localparam int N_EXP        = (SINGLE_GROUP != 0) ? EXP_SINGLE : EXP_MULTI,
  localparam int N_IN         = N_DED + N_ICL + N_MCF + N_EXP,
  localparam int IDX_W        = $clog2(N_EXP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [N_IN-1:0]  cfg_true,
  input  logic [N_IN-1:0]  cfg_comp,
  input  logic [N_DED-1:0] ded_i,
  input  logic [N_ICL-1:0] icl_i,
  input  logic [N_MCF-1:0] mcf_i,
  output logic [N_EXP-1:0] exp_o
);
  localparam int COL_ICL = N_DED;
  localparam int COL_MCF = COL_ICL + N_ICL;
  localparam int COL_FB  = COL_MCF + N_MCF;

  logic                       rst_s_n;
  logic [N_EXP-1:0][N_IN-1:0] fuse_t;
  logic [N_EXP-1:0][N_IN-1:0] fuse_c;
  logic [N_EXP-1:0]           fb_q;
  logic [N_ICL-1:0]           icl_eff;
  logic [N_IN-1:0]            lit_x;
  logic                       fb_en;

  sxa_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sxa_fuse_bank #(.N_EXP(N_EXP), .N_IN(N_IN)) u_fuse (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .t_in  (cfg_true),
    .c_in  (cfg_comp),
    .t_q   (fuse_t),
    .c_q   (fuse_c)
  );

  // A lone group has no interconnect lines: those columns read low.
  if (SINGLE_GROUP != 0) begin : g_single
    assign icl_eff = '0;
  end else begin : g_multi
    assign icl_eff = icl_i;
  end

  always_comb begin
    lit_x                        = '0;
    lit_x[COL_ICL-1:0]           = ded_i;
    lit_x[COL_MCF-1:COL_ICL]     = icl_eff;
    lit_x[COL_FB-1:COL_MCF]      = mcf_i;
    lit_x[N_IN-1:COL_FB]         = fb_q;
  end

  for (genvar k = 0; k < N_EXP; k++) begin : g_exp
    sxa_term #(.N_IN(N_IN)) u_term (
      .t_sel  (fuse_t[k]),
      .c_sel  (fuse_c[k]),
      .lit_x  (lit_x),
      .term_n (exp_o[k])
    );
  end

  assign fb_en = 1'b1;

  sxa_fb_reg #(.W(N_EXP)) u_fb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (fb_en),
    .d     (exp_o),
    .q     (fb_q)
  );
endmodule

// File: rtl/sxa_array_chk.sv
module sxa_array_chk #(
  parameter  int N_EXP = 32,
  parameter  int N_IN  = 80,
  localparam int IDX_W = $clog2(N_EXP)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rst_s_n,
  input logic                       cfg_we,
  input logic [IDX_W-1:0]           cfg_idx,
  input logic [N_IN-1:0]            cfg_true,
  input logic [N_IN-1:0]            cfg_comp,
  input logic [N_EXP-1:0][N_IN-1:0] fuse_t,
  input logic [N_EXP-1:0][N_IN-1:0] fuse_c,
  input logic [N_EXP-1:0]           fb_q,
  input logic [N_EXP-1:0]           exp_o
);
  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (exp_o == '0)); // R1

  AST_CFG_APPLY: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_we |=> (fuse_t[$past(cfg_idx)] == $past(cfg_true)) &&
               (fuse_c[$past(cfg_idx)] == $past(cfg_comp))); // R2

  AST_FUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_we |=> $stable(fuse_t) && $stable(fuse_c)); // R2

  AST_FB_TRACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    fb_q == $past(exp_o)); // R5

  for (genvar k = 0; k < N_EXP; k++) begin : g_empty
    AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_s_n)
      ((fuse_t[k] == '0) && (fuse_c[k] == '0)) |-> !exp_o[k]); // R6
  end
endmodule

bind shared_expander_array sxa_array_chk #(.N_EXP(N_EXP), .N_IN(N_IN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_s_n  (rst_s_n),
  .cfg_we   (cfg_we),
  .cfg_idx  (cfg_idx),
  .cfg_true (cfg_true),
  .cfg_comp (cfg_comp),
  .fuse_t   (fuse_t),
  .fuse_c   (fuse_c),
  .fb_q     (fb_q),
  .exp_o    (exp_o)
);

// File: tb/sim_shared_expander_array.sv
`timescale 1ns/1ps
module sim_shared_expander_array;
  localparam int NE = 32;
  localparam int NI = 80;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [4:0]    cfg_idx;
  logic [NI-1:0] cfg_true;
  logic [NI-1:0] cfg_comp;
  logic [7:0]    ded_i;
  logic [23:0]   icl_i;
  logic [15:0]   mcf_i;
  logic [NE-1:0] exp_o;

  shared_expander_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_true(cfg_true), .cfg_comp(cfg_comp), .ded_i(ded_i),
    .icl_i(icl_i), .mcf_i(mcf_i), .exp_o(exp_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [NI-1:0] mt [NE];
  logic [NI-1:0] mc [NE];
  logic [NE-1:0] fb_m;

  logic [NE-1:0] exp_q [$];
  string         tag_q [$];
  event          mon_ev;

  function automatic logic [NE-1:0] model(input logic [7:0] d, input logic [23:0] i,
                                          input logic [15:0] m);
    logic [NI-1:0] x;
    logic [NE-1:0] r;
    x = {fb_m, m, i, d};
    for (int k = 0; k < NE; k++) r[k] = ~(&((x | ~mt[k]) & (~x | ~mc[k])));
    return r;
  endfunction

  function automatic logic [NI-1:0] sparse();
    logic [NI-1:0] v = '0;
    for (int j = 0; j < NI; j++) v[j] = ($urandom % 24) == 0;
    return v;
  endfunction

  task automatic cyc(input bit we, input int idx, input logic [NI-1:0] t,
                     input logic [NI-1:0] c, input logic [7:0] d, input logic [23:0] i,
                     input logic [15:0] m, input bit chk, input string tag);
    logic [NE-1:0] e;
    @(negedge clk);
    cfg_we = we; cfg_idx = 5'(idx); cfg_true = t; cfg_comp = c;
    ded_i = d; icl_i = i; mcf_i = m;
    e = model(d, i, m);
    if (chk) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
      ->mon_ev;
    end
    @(posedge clk);
    fb_m = e;
    if (we && rst_n) begin mt[idx] = t; mc[idx] = c; end
  endtask

  task automatic wr(input int idx, input logic [NI-1:0] t, input logic [NI-1:0] c,
                    input string tag);
    cyc(1'b1, idx, t, c, ded_i, icl_i, mcf_i, 1'b1, tag);
  endtask

  task automatic drv(input logic [7:0] d, input logic [23:0] i, input logic [15:0] m,
                     input string tag);
    cyc(1'b0, 0, '0, '0, d, i, m, 1'b1, tag);
  endtask

  task automatic direct(input bit a, input bit b, input string tag);
    @(negedge clk); #3;
    tests++;
    if (exp_o[10] !== a || exp_o[11] !== b) begin
      fails++;
      $display("FAIL %s latch got %b%b exp %b%b", tag, exp_o[10], exp_o[11], a, b);
    end
  endtask

  // Monitor: pop the expected bus and compare with the port.
  initial begin
    forever begin
      logic [NE-1:0] e;
      string         tg;
      @(mon_ev);
      #2;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      tests++;
      if (exp_o !== e) begin
        fails++;
        $display("FAIL %s exp_o got %h exp %h", tg, exp_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NI-1:0] t, c;
    for (int k = 0; k < NE; k++) begin mt[k] = '0; mc[k] = '0; end
    fb_m = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_true = '0; cfg_comp = '0;
    ded_i = '0; icl_i = '0; mcf_i = '0;

    // R1: outputs low in reset whatever the inputs
    drv(8'hA5, 24'h123456, 16'hBEEF, "R1 in reset");
    drv(8'hFF, 24'hFFFFFF, 16'hFFFF, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drv(8'h3C, 24'h0F0F0F, 16'h00FF, "R1 after release");

    // R3 R4: single literals at known columns
    t = '0; t[0] = 1'b1;
    wr(0, t, '0, "R2 write e0");
    drv(8'h00, '0, '0, "R3 e0 ded0 low");
    drv(8'h01, '0, '0, "R3 e0 ded0 high");
    t = '0; c = '0; c[8] = 1'b1; t[35] = 1'b1;
    wr(1, t, c, "R2 write e1");
    drv(8'h00, 24'h000000, 16'h0008, "R4 e1 icl0 low mcf3 high");
    drv(8'h00, 24'h000001, 16'h0008, "R4 e1 icl0 high");
    drv(8'h00, 24'h000000, 16'h0000, "R4 e1 mcf3 low");

    // R5: expander 2 follows expander 0 through feedback column 48
    t = '0; t[48] = 1'b1;
    wr(2, t, '0, "R2 write e2");
    drv(8'h01, '0, '0, "R5 fb settle");
    drv(8'h00, '0, '0, "R5 fb lag");
    drv(8'h00, '0, '0, "R5 fb follow");
    drv(8'h01, '0, '0, "R5 fb lag");

    // R6: contradictory literal and empty term
    t = '0; t[2] = 1'b1; c = '0; c[2] = 1'b1;
    wr(5, t, c, "R2 write e5");
    drv(8'h04, '0, '0, "R6 contradiction");
    drv(8'h00, '0, '0, "R6 contradiction");
    wr(0, '0, '0, "R2 overwrite e0 empty");
    drv(8'hFF, '0, '0, "R6 empty term");

    // R3: random sparse NAND configurations
    for (int k = 0; k < NE; k++) wr(k, sparse(), sparse(), "R2 random write");
    for (int n = 0; n < 60; n++)
      drv(8'($urandom), 24'($urandom), 16'($urandom), "R3 random");

    // R7: cross-coupled pair 10/11 as a set-reset latch
    t = '0; t[1] = 1'b1; t[48+11] = 1'b1;
    wr(10, t, '0, "R2 write e10");
    t = '0; t[2] = 1'b1; t[48+10] = 1'b1;
    wr(11, t, '0, "R2 write e11");
    repeat (2) drv(8'h04, '0, '0, "R7 set");
    repeat (3) drv(8'h06, '0, '0, "R7 hold after set");
    direct(1'b1, 1'b0, "R7 set state");
    repeat (2) drv(8'h02, '0, '0, "R7 reset");
    repeat (3) drv(8'h06, '0, '0, "R7 hold after reset");
    direct(1'b0, 1'b1, "R7 reset state");
    repeat (2) drv(8'h04, '0, '0, "R7 set again");
    drv(8'h06, '0, '0, "R7 hold");
    direct(1'b1, 1'b0, "R7 set again state");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule